// File: doc/BRIEF.md
# Shared-Pin Hardware Reset Qualifier

This block lives inside a serial flash interface controller. One package pin does two jobs: it is data line 3 in quad transfers and an active-low hardware reset input the rest of the time. The block watches a synchronised copy of that pin. It decides from the mode bits, chip select, power-up status and the length of a low pulse whether the low level is a real reset request.

When a request qualifies, the block aborts the current access, floats all outputs and rejects commands. It then holds the interface in a warm-reset phase of fixed length, or starts a full power-on sequence if the earlier power-on reset did not finish cleanly. After either phase it waits until the pin has been high long enough before it returns to standby. A software reset strobe enters the warm reset directly. A separate small timer drives line 3 high at the end of each quad read. A sticky error bit records every low pulse that was too short, or that arrived inside the recovery window.

All timings are clock-cycle parameters: `T_CS`, `T_RP`, `T_RPH`, `T_PU`, `T_RS`, `T_RH` and `T_DIS`. The recovery length is `T_HOLD = max(T_RS, T_RH)`.

Top module: `io3_rst_qual`

## Requirements
- R1: The pin passes through a two-flop synchroniser. A reset is recognised when the synchroniser output gives `T_RP` consecutive qualified low samples. A pin low for L clock cycles starting just after edge 0 sets `rst_active_o` after edge `T_RP+2` when L >= `T_RP`, and never when L < `T_RP`.
- R2: With `quad_en_i`=0 the pin is a reset input whatever the levels of `cs_ni` and `rst_feat_en_i`.
- R3: With `quad_en_i`=1 and `rst_feat_en_i`=0 a low on the pin never causes a reset.
- R4: With `quad_en_i`=1 and `rst_feat_en_i`=1 the pin is ignored while `cs_ni` is low, and for the first `T_CS` clock edges after `cs_ni` goes high.
- R5: A recognised reset with `por_ok_i`=1 holds `rst_active_o` high for exactly `T_RPH` cycles. `out_hiz_o` and `cmd_ignore_o` are high whenever `rst_active_o` is high.
- R6: A recognised reset with `por_ok_i`=0 raises `por_req_o` and `rst_active_o` for exactly `T_PU` cycles instead.
- R7: After either reset phase, `rst_active_o` drops. `out_hiz_o` and `cmd_ignore_o` stay high until the pin has been sampled high on `T_HOLD` consecutive edges.
- R8: While `pu_done_i` is low the pin is ignored and `cmd_ignore_o` is high. If the pin is low when `pu_done_i` rises, the block goes directly to the recovery phase of R7.
- R9: A one-cycle `sw_rst_i` in standby starts the `T_RPH` warm reset on the next edge, whatever the pin level or `por_ok_i`.
- R10: A one-cycle `quad_rd_end_i` in standby sets `drive_hi_o` for exactly `T_DIS` cycles from the next edge. `drive_hi_o` is never high while `out_hiz_o` is high.
- R11: `pulse_err_o` is set by a qualified low pulse of 1 to `T_RP-1` samples, and by a low sample in the recovery phase after the pin had been seen high there. Only `rst_ni` clears it.
- R12: After `rst_ni` all outputs are low, except `cmd_ignore_o`, which equals the inverse of `pu_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Level on the shared data-3/reset pin |
| cs_ni | input | 1 | Chip select, active low |
| rst_feat_en_i | input | 1 | Reset function enabled on the shared pin |
| quad_en_i | input | 1 | Quad mode enabled |
| pu_done_i | input | 1 | Power-up period finished |
| por_ok_i | input | 1 | Last power-on reset finished correctly |
| sw_rst_i | input | 1 | Software reset command strobe |
| quad_rd_end_i | input | 1 | Strobe at end of a quad read |
| rst_active_o | output | 1 | Warm reset or power-on sequence running |
| por_req_o | output | 1 | Full power-on sequence requested |
| out_hiz_o | output | 1 | Force all outputs to high impedance |
| cmd_ignore_o | output | 1 | Reject read and write commands |
| drive_hi_o | output | 1 | Drive line 3 high before release |
| pulse_err_o | output | 1 | Sticky short or early low pulse flag |

## Verification
Low pulse width is swept from one cycle to two cycles past `T_RP`, in each mode. An off-by-one in the width counter or the synchroniser shows up as a reset one width too early or too late, or as a missing or spurious error flag. The blanking window is tested at the two widths on either side of the threshold after chip select rises. A design that started counting on the chip-select edge would accept the shorter one. Reset, power-on and recovery lengths are counted cycle by cycle, and this catches a timer that ends one cycle off, or a recovery that ignores the pin. Software reset, the power-up hold and the drive-high timer, including a drive-high request killed by a concurrent reset, are each checked at their own boundary.

// File: rtl/io3_rst_pkg.sv
package io3_rst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HWRST = 2'd1,
    ST_POR   = 2'd2,
    ST_HOLD  = 2'd3
  } rst_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/io3_sync.sv
module io3_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/io3_pulse_qual.sv
module io3_pulse_qual #(
  parameter int T_CS = 5,
  parameter int T_RP = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic cs_ni,
  input  logic quad_en_i,
  input  logic feat_en_i,
  input  logic arm_i,
  output logic trig_o,
  output logic short_o
);
  localparam int CSW = $clog2(T_CS + 1);
  localparam int RPW = $clog2(T_RP + 1);

  logic [CSW-1:0] cs_cnt;
  logic [RPW-1:0] low_cnt;
  logic           blank_done, pin_is_rst, qual_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cs_cnt <= '0;
    else if (!cs_ni)               cs_cnt <= '0;
    else if (cs_cnt != CSW'(T_CS)) cs_cnt <= cs_cnt + 1'b1;
  end

  assign blank_done = cs_ni && (cs_cnt == CSW'(T_CS));
  assign pin_is_rst = !quad_en_i || (feat_en_i && blank_done);
  assign qual_low   = arm_i && pin_is_rst && !pin_s_i;
  assign trig_o     = qual_low && (low_cnt == RPW'(T_RP - 1));
  // high after a partial count = pulse too short
  assign short_o    = arm_i && pin_s_i && (low_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_cnt <= '0;
    else if (!qual_low || trig_o) low_cnt <= '0;
    else                         low_cnt <= low_cnt + 1'b1;
  end

  assert_cnt_below_rp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt < RPW'(T_RP));
  assert_quad_nofeat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_en_i && !feat_en_i) |-> !trig_o);
  assert_cs_low_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_en_i && !cs_ni) |=> (low_cnt == '0));
  assert_cs_rise_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_en_i && $rose(cs_ni)) |-> !trig_o);
endmodule

// File: rtl/io3_rst_seq.sv
module io3_rst_seq
  import io3_rst_pkg::*;
#(
  parameter int T_RPH = 3500,
  parameter int T_PU  = 30000,
  parameter int T_RS  = 5,
  parameter int T_RH  = 5,
  parameter int T_DIS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic pu_done_i,
  input  logic por_ok_i,
  input  logic sw_rst_i,
  input  logic trig_i,
  input  logic short_i,
  input  logic rd_end_i,
  output logic arm_o,
  output logic rst_active_o,
  output logic por_req_o,
  output logic out_hiz_o,
  output logic cmd_ignore_o,
  output logic drive_hi_o,
  output logic err_o
);
  localparam int T_HOLD = max2(T_RS, T_RH);
  localparam int TW     = $clog2(max2(T_RPH, T_PU) + 1);
  localparam int HW     = $clog2(T_HOLD + 1);
  localparam int DW     = $clog2(T_DIS + 1);

  rst_state_e    state, state_n;
  logic [TW-1:0] tmr;
  logic [HW-1:0] hold_cnt;
  logic [DW-1:0] dis_cnt;
  logic          pu_q, pu_rise, err_q;

  assign pu_rise = pu_done_i && !pu_q;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: begin
        if (sw_rst_i)                state_n = ST_HWRST;
        else if (trig_i)             state_n = por_ok_i ? ST_HWRST : ST_POR;
        else if (pu_rise && !pin_s_i) state_n = ST_HOLD;
      end
      ST_HWRST: if (tmr == TW'(T_RPH - 1)) state_n = ST_HOLD;
      ST_POR:   if (tmr == TW'(T_PU - 1))  state_n = ST_HOLD;
      ST_HOLD:  if (pin_s_i && hold_cnt == HW'(T_HOLD - 1)) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      hold_cnt <= '0;
      dis_cnt  <= '0;
      pu_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state <= state_n;
      pu_q  <= pu_done_i;
      if (state_n != state || !(state == ST_HWRST || state == ST_POR)) tmr <= '0;
      else tmr <= tmr + 1'b1;
      if (state != ST_HOLD || !pin_s_i) hold_cnt <= '0;
      else                              hold_cnt <= hold_cnt + 1'b1;
      if (short_i || (state == ST_HOLD && !pin_s_i && hold_cnt != '0)) err_q <= 1'b1;
      if (state_n != ST_IDLE)  dis_cnt <= '0;
      else if (rd_end_i)       dis_cnt <= DW'(T_DIS);
      else if (dis_cnt != '0)  dis_cnt <= dis_cnt - 1'b1;
    end
  end

  assign arm_o        = (state == ST_IDLE) && pu_done_i && pu_q;
  assign rst_active_o = (state == ST_HWRST) || (state == ST_POR);
  assign por_req_o    = (state == ST_POR);
  assign out_hiz_o    = (state != ST_IDLE);
  assign cmd_ignore_o = (state != ST_IDLE) || !pu_done_i;
  assign drive_hi_o   = (dis_cnt != '0);
  assign err_o        = err_q;

  assert_por_only_on_fail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_req_o) |-> !$past(por_ok_i));
  assert_sw_rst_warm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && sw_rst_i) |=> (rst_active_o && !por_req_o));
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_no_drive_in_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hiz_o |-> !drive_hi_o);
  assert_hold_needs_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_HOLD && state == ST_IDLE) |-> $past(pin_s_i));
endmodule

// File: rtl/io3_rst_qual.sv
module io3_rst_qual #(
  parameter int T_CS  = 5,
  parameter int T_RP  = 20,
  parameter int T_RPH = 3500,
  parameter int T_PU  = 30000,
  parameter int T_RS  = 5,
  parameter int T_RH  = 5,
  parameter int T_DIS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic cs_ni,
  input  logic rst_feat_en_i,
  input  logic quad_en_i,
  input  logic pu_done_i,
  input  logic por_ok_i,
  input  logic sw_rst_i,
  input  logic quad_rd_end_i,
  output logic rst_active_o,
  output logic por_req_o,
  output logic out_hiz_o,
  output logic cmd_ignore_o,
  output logic drive_hi_o,
  output logic pulse_err_o
);
  logic pin_s, arm, trig, short_p;

  io3_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  io3_pulse_qual #(.T_CS(T_CS), .T_RP(T_RP)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_s_i  (pin_s),
    .cs_ni    (cs_ni),
    .quad_en_i(quad_en_i),
    .feat_en_i(rst_feat_en_i),
    .arm_i    (arm),
    .trig_o   (trig),
    .short_o  (short_p)
  );

  io3_rst_seq #(
    .T_RPH(T_RPH), .T_PU(T_PU), .T_RS(T_RS), .T_RH(T_RH), .T_DIS(T_DIS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_s_i     (pin_s),
    .pu_done_i   (pu_done_i),
    .por_ok_i    (por_ok_i),
    .sw_rst_i    (sw_rst_i),
    .trig_i      (trig),
    .short_i     (short_p),
    .rd_end_i    (quad_rd_end_i),
    .arm_o       (arm),
    .rst_active_o(rst_active_o),
    .por_req_o   (por_req_o),
    .out_hiz_o   (out_hiz_o),
    .cmd_ignore_o(cmd_ignore_o),
    .drive_hi_o  (drive_hi_o),
    .err_o       (pulse_err_o)
  );

  assert_hiz_covers_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_o |-> (out_hiz_o && cmd_ignore_o));
  assert_no_reset_before_pu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pu_done_i && !rst_active_o && !sw_rst_i) |=> !rst_active_o);
endmodule

// File: tb/sim_io3_rst_qual.sv
`timescale 1ns/1ps
module sim_io3_rst_qual;
  localparam int T_CS = 4, T_RP = 5, T_RPH = 12, T_PU = 20, T_RS = 3, T_RH = 4, T_DIS = 3;
  localparam int T_HOLD = (T_RS > T_RH) ? T_RS : T_RH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b1, cs_n = 1'b1, feat = 1'b0, quad = 1'b0, pu = 1'b1, por_ok = 1'b1;
  logic sw = 1'b0, rd_end = 1'b0;
  logic ra, por, hz, ign, drv, err;
  int checks = 0, fails = 0;
  int first_ra, ra_cnt, hz_cnt, por_cnt, drv_cnt, first_drv, ign_cnt;

  always #2.5 clk = ~clk;

  io3_rst_qual #(.T_CS(T_CS), .T_RP(T_RP), .T_RPH(T_RPH), .T_PU(T_PU),
                 .T_RS(T_RS), .T_RH(T_RH), .T_DIS(T_DIS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cs_ni(cs_n), .rst_feat_en_i(feat),
    .quad_en_i(quad), .pu_done_i(pu), .por_ok_i(por_ok), .sw_rst_i(sw),
    .quad_rd_end_i(rd_end), .rst_active_o(ra), .por_req_o(por), .out_hiz_o(hz),
    .cmd_ignore_o(ign), .drive_hi_o(drv), .pulse_err_o(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pin = 1'b1; sw = 1'b0; rd_end = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // caller sets stimulus at a negedge (cycle 0); pin released at negedge L
  task automatic measure(input int n, input int len, input int glitch_at);
    first_ra = -1; first_drv = -1;
    ra_cnt = 0; hz_cnt = 0; por_cnt = 0; drv_cnt = 0; ign_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (ra && first_ra < 0) first_ra = i;
      if (drv && first_drv < 0) first_drv = i;
      ra_cnt += int'(ra); hz_cnt += int'(hz); por_cnt += int'(por);
      drv_cnt += int'(drv); ign_cnt += int'(ign);
      sw = 1'b0; rd_end = 1'b0;
      if (i == len) pin = 1'b1;
      if (glitch_at != 0 && i == glitch_at) pin = 1'b0;
      if (glitch_at != 0 && i == glitch_at + 1) pin = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 rst_active", int'(ra), 0); chk("R12 por_req", int'(por), 0);
    chk("R12 out_hiz", int'(hz), 0);    chk("R12 cmd_ignore", int'(ign), 0);
    chk("R12 drive_hi", int'(drv), 0);  chk("R12 pulse_err", int'(err), 0);

    // R1 R2 R5 R7 R11: width sweep, quad off, cs and feature varied
    for (int l = 1; l <= T_RP + 2; l++) begin
      bit rec;
      rec = (l >= T_RP);
      quad = 1'b0; feat = l[0]; cs_n = l[1];
      do_reset();
      pin = 1'b0;
      measure(60, l, 0);
      chk("R1 first reset cycle", first_ra, rec ? T_RP + 2 : -1);
      chk("R5 warm reset length", ra_cnt, rec ? T_RPH : 0);
      chk("R7 hiz incl recovery", hz_cnt, rec ? T_RPH + T_HOLD : 0);
      chk("R11 short pulse flag", int'(err), rec ? 0 : 1);
      chk("R2 no por", por_cnt, 0);
    end

    // R7 pin held low past warm reset
    quad = 1'b0; cs_n = 1'b1; do_reset();
    pin = 1'b0;
    measure(60, T_RP + T_RPH + 3, 0);
    chk("R7 recovery waits for pin", hz_cnt, T_RPH + 3 + T_HOLD);
    chk("R7 rst_active length", ra_cnt, T_RPH);
    chk("R11 no err on long low", int'(err), 0);

    // R3 quad on, feature off
    quad = 1'b1; feat = 1'b0; cs_n = 1'b1; do_reset();
    pin = 1'b0;
    measure(40, 30, 0);
    chk("R3 feature off ignored", ra_cnt + hz_cnt, 0);
    chk("R3 no err", int'(err), 0);

    // R4 quad on, feature on, cs low
    quad = 1'b1; feat = 1'b1; cs_n = 1'b0; do_reset();
    pin = 1'b0;
    measure(40, 30, 0);
    chk("R4 cs low ignored", ra_cnt + hz_cnt, 0);
    chk("R4 no err", int'(err), 0);

    // R4 blanking threshold after cs rise
    for (int d = 0; d < 2; d++) begin
      quad = 1'b1; feat = 1'b1; cs_n = 1'b0; do_reset();
      cs_n = 1'b1; pin = 1'b0;
      measure(60, T_CS + T_RP - 3 + d, 0);
      chk("R4 blanking first reset", first_ra, (d == 1) ? T_CS + T_RP : -1);
      chk("R11 blank short flag", int'(err), (d == 1) ? 0 : 1);
    end

    // R6 full power-on sequence
    quad = 1'b0; por_ok = 1'b0; do_reset();
    pin = 1'b0;
    measure(60, T_RP, 0);
    chk("R6 first reset", first_ra, T_RP + 2);
    chk("R6 por length", por_cnt, T_PU);
    chk("R6 active length", ra_cnt, T_PU);
    chk("R6 hiz length", hz_cnt, T_PU + T_HOLD);
    por_ok = 1'b1;

    // R9 software reset, pin level irrelevant
    for (int v = 0; v < 2; v++) begin
      quad = 1'b1; feat = 1'b0; por_ok = 1'b0; do_reset();
      sw = 1'b1; pin = v[0] ? 1'b0 : 1'b1;
      measure(40, v[0] ? 3 : 0, 0);
      chk("R9 sw reset start", first_ra, 1);
      chk("R9 sw reset length", ra_cnt, T_RPH);
      chk("R9 sw not por", por_cnt, 0);
      chk("R9 hiz length", hz_cnt, T_RPH + T_HOLD);
    end
    por_ok = 1'b1;

    // R10 drive-high timer, and killed by concurrent reset
    quad = 1'b1; feat = 1'b1; cs_n = 1'b1; do_reset();
    rd_end = 1'b1;
    measure(10, 0, 0);
    chk("R10 drive start", first_drv, 1);
    chk("R10 drive length", drv_cnt, T_DIS);
    do_reset();
    rd_end = 1'b1; sw = 1'b1;
    measure(30, 0, 0);
    chk("R10 drive during reset", drv_cnt, 0);

    // R8 power-up
    quad = 1'b0; pu = 1'b0; do_reset();
    pin = 1'b0;
    measure(30, 0, 0);
    chk("R8 ignored before pu", ra_cnt + hz_cnt, 0);
    chk("R8 cmd_ignore before pu", ign_cnt, 30);
    pu = 1'b1;
    measure(30, 3, 0);
    chk("R8 hold after pu", hz_cnt, 4 + T_HOLD);
    chk("R8 no reset pulse", ra_cnt, 0);
    chk("R8 no err", int'(err), 0);

    // R11 low inside recovery window
    quad = 1'b0; do_reset();
    pin = 1'b0;
    measure(60, T_RP, T_RP + 2 + T_RPH);
    chk("R11 early low flag", int'(err), 1);
    chk("R11 reset length", ra_cnt, T_RPH);
    chk("R11 back to idle", int'(hz), 0);
    do_reset();
    chk("R11 cleared by rst_ni", int'(err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule